// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Unit

This unit sits beside the inbound memory-write path of a PCIe root port. When a write lands on one programmed 64-bit target address while interrupt reception is enabled, the write is taken as an interrupt message. The unit then does three things:

- It sets one of 32 per-vector status bits. The vector number comes from the low five bits of the written data.
- It stores the low byte of that data in a payload register.
- It drives a level pending output toward the first-level interrupt aggregator.

Software uses a small register window to:

- program the target address in two 32-bit halves;
- mask individual vectors;
- read the payload byte;
- clear each serviced status bit by writing a one to it.

The pending level is the OR of all status bits that are not masked. It stays high until every such bit has been cleared.

Top module: `msi_capture_unit`

## Requirements
- R1: After reset, every register reads zero and `msi_pending` is low.
- R2: An inbound write with `in_wr_valid` high, `msi_en` high and `in_wr_addr` equal to {high half, low half} of the target sets status bit `in_wr_data_lo[4:0]` on the next clock edge.
- R3: An inbound write to any other address, or any inbound write while `msi_en` is low, changes neither the status bits nor the payload.
- R4: A captured write stores `in_wr_data_lo[7:0]` in the payload register. The payload register (index 4) reads that byte in bits 7:0 and zero in bits 31:8.
- R5: A register write to the status register (index 2) clears exactly the status bits whose write-data bit is 1. Bits written 0 are kept.
- R6: When a capture and a status clear hit the same vector in the same cycle, the bit ends up set.
- R7: `msi_pending` is high exactly while some status bit is set whose mask bit is 0. A mask of all zeros enables every vector, and a mask of all ones forces the output low.
- R8: A mask bit only blocks the pending output. A masked vector still has its status bit set by a capture.
- R9: The target low half (index 0) and high half (index 1) read back as written. A write that differs from the target only in the high half is not captured.
- R10: The register index is 3 bits. Indices 0 to 4 are mapped. Writes to the payload index are ignored, and indices 5 to 7 read zero and accept no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_en | input | 1 | Interrupt-message reception enable from the core control register |
| in_wr_valid | input | 1 | An inbound memory write is present this cycle |
| in_wr_addr | input | 64 | Inbound write address |
| in_wr_data_lo | input | 8 | Low byte of the inbound write data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from the registers |
| msi_pending | output | 1 | Level: some unmasked vector is pending |

## Verification
The checker assumes the inbound write fields are valid only while `in_wr_valid` is high. It also assumes that a capture and a register write may arrive together on any cycle, so it makes no ordering assumption between the two paths. The bench changes inputs only at the falling edge and keeps every input at a known value from reset onward. It drives captures together with clears, and with target and mask writes, so that same-cycle priorities are exercised.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RI_ADDR_LO = 3'd0,
        RI_ADDR_HI = 3'd1,
        RI_STATUS  = 3'd2,
        RI_MASK    = 3'd3,
        RI_PAYLOAD = 3'd4
    } reg_idx_e;
endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match #(
    parameter int ADDR_W = 64
) (
    input  logic              wr_valid,
    input  logic              enable,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] target,
    output logic              hit
);
    assign hit = wr_valid && enable && (wr_addr == target);
endmodule

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
    parameter int NUM_VEC = 32,
    localparam int VIDX_W = $clog2(NUM_VEC)
) (
    input  logic              fire,
    input  logic [VIDX_W-1:0] vidx,
    output logic [NUM_VEC-1:0] set_vec
);
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
        assign set_vec[i] = fire && (vidx == VIDX_W'(i));
    end
endmodule

// File: rtl/msi_read_mux.sv
module msi_read_mux
    import msi_cap_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_VEC   = 32,
    parameter int PAYLOAD_W = 8
) (
    input  logic [REG_AW-1:0]    idx,
    input  logic [DATA_W-1:0]    addr_lo,
    input  logic [DATA_W-1:0]    addr_hi,
    input  logic [NUM_VEC-1:0]   stat,
    input  logic [NUM_VEC-1:0]   mask,
    input  logic [PAYLOAD_W-1:0] pay,
    output logic [DATA_W-1:0]    rdata
);
    always_comb begin
        case (idx)
            RI_ADDR_LO: rdata = addr_lo;
            RI_ADDR_HI: rdata = addr_hi;
            RI_STATUS:  rdata = DATA_W'(stat);
            RI_MASK:    rdata = DATA_W'(mask);
            RI_PAYLOAD: rdata = DATA_W'(pay);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/msi_capture_unit.sv
module msi_capture_unit
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC   = 32,
    parameter int DATA_W    = 32,
    parameter int PAYLOAD_W = 8,
    localparam int ADDR_W   = 2 * DATA_W,
    localparam int VIDX_W   = $clog2(NUM_VEC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msi_en,
    input  logic                 in_wr_valid,
    input  logic [ADDR_W-1:0]    in_wr_addr,
    input  logic [PAYLOAD_W-1:0] in_wr_data_lo,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 msi_pending
);
    typedef struct packed {
        logic [DATA_W-1:0]    addr_lo;
        logic [DATA_W-1:0]    addr_hi;
        logic [NUM_VEC-1:0]   status;
        logic [NUM_VEC-1:0]   mask;
        logic [PAYLOAD_W-1:0] payload;
    } cap_state_t;

    cap_state_t st_d, st_q;

    logic [ADDR_W-1:0]    target;
    logic [NUM_VEC-1:0]   stat_v;
    logic [NUM_VEC-1:0]   mask_v;
    logic [PAYLOAD_W-1:0] pay_v;
    logic                 hit;
    logic [NUM_VEC-1:0]   set_vec;
    logic [NUM_VEC-1:0]   clr_vec;

    assign target = {st_q.addr_hi, st_q.addr_lo};
    assign stat_v = st_q.status;
    assign mask_v = st_q.mask;
    assign pay_v  = st_q.payload;

    msi_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .wr_valid (in_wr_valid),
        .enable   (msi_en),
        .wr_addr  (in_wr_addr),
        .target   (target),
        .hit      (hit)
    );

    msi_vec_decode #(.NUM_VEC(NUM_VEC)) u_decode (
        .fire    (hit),
        .vidx    (in_wr_data_lo[VIDX_W-1:0]),
        .set_vec (set_vec)
    );

    msi_read_mux #(
        .DATA_W    (DATA_W),
        .NUM_VEC   (NUM_VEC),
        .PAYLOAD_W (PAYLOAD_W)
    ) u_rmux (
        .idx     (reg_addr),
        .addr_lo (st_q.addr_lo),
        .addr_hi (st_q.addr_hi),
        .stat    (stat_v),
        .mask    (mask_v),
        .pay     (pay_v),
        .rdata   (reg_rdata)
    );

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (reg_wr) begin
            case (reg_addr)
                RI_ADDR_LO: st_d.addr_lo = reg_wdata;
                RI_ADDR_HI: st_d.addr_hi = reg_wdata;
                RI_STATUS:  clr_vec      = reg_wdata[NUM_VEC-1:0];
                RI_MASK:    st_d.mask    = reg_wdata[NUM_VEC-1:0];
                default:    ;
            endcase
        end
        // a fresh capture outranks a clear of the same vector
        st_d.status = (st_q.status & ~clr_vec) | set_vec;
        if (hit) begin
            st_d.payload = in_wr_data_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msi_pending = |(stat_v & ~mask_v);
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
    parameter int NUM_VEC   = 32,
    parameter int DATA_W    = 32,
    parameter int PAYLOAD_W = 8,
    localparam int ADDR_W   = 2 * DATA_W,
    localparam int VIDX_W   = $clog2(NUM_VEC)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 msi_en,
    input logic                 in_wr_valid,
    input logic [ADDR_W-1:0]    in_wr_addr,
    input logic [PAYLOAD_W-1:0] in_wr_data_lo,
    input logic                 reg_wr,
    input logic [2:0]           reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic                 msi_pending,
    input logic [ADDR_W-1:0]    target,
    input logic [NUM_VEC-1:0]   stat,
    input logic [NUM_VEC-1:0]   mask,
    input logic [PAYLOAD_W-1:0] pay
);
    logic cap;
    logic st_wr;
    assign cap   = in_wr_valid && msi_en && (in_wr_addr == target);
    assign st_wr = reg_wr && (reg_addr == 3'd2);

    assert_capture_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> stat[$past(in_wr_data_lo[VIDX_W-1:0])]);

    assert_status_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !st_wr) |=> (stat == $past(stat)));

    assert_payload_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> (pay == $past(pay)));

    assert_payload_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (pay == $past(in_wr_data_lo)));

    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !cap) |=> ((stat & $past(reg_wdata[NUM_VEC-1:0])) == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && cap) |=> stat[$past(in_wr_data_lo[VIDX_W-1:0])]);

    assert_pending_needs_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pending |-> ((stat & ~mask) != '0));

    assert_full_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !msi_pending);
endmodule

bind msi_capture_unit msi_capture_chk #(
    .NUM_VEC   (NUM_VEC),
    .DATA_W    (DATA_W),
    .PAYLOAD_W (PAYLOAD_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .msi_en        (msi_en),
    .in_wr_valid   (in_wr_valid),
    .in_wr_addr    (in_wr_addr),
    .in_wr_data_lo (in_wr_data_lo),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .msi_pending   (msi_pending),
    .target        (target),
    .stat          (stat_v),
    .mask          (mask_v),
    .pay           (pay_v)
);

// File: tb/tb_msi_capture_unit.sv
module tb_msi_capture_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_en = 1'b0;
    logic        in_wr_valid = 1'b0;
    logic [63:0] in_wr_addr = '0;
    logic [7:0]  in_wr_data_lo = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msi_pending;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit [31:0] m_lo, m_hi, m_stat, m_mask;
    bit [7:0]  m_pay;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_capture_unit dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .msi_en        (msi_en),
        .in_wr_valid   (in_wr_valid),
        .in_wr_addr    (in_wr_addr),
        .in_wr_data_lo (in_wr_data_lo),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .msi_pending   (msi_pending)
    );

    function automatic bit [31:0] m_read(input bit [2:0] idx);
        case (idx)
            3'd0:    return m_lo;
            3'd1:    return m_hi;
            3'd2:    return m_stat;
            3'd3:    return m_mask;
            3'd4:    return {24'h0, m_pay};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit        cap;
        bit [31:0] clr;
        cap = in_wr_valid && msi_en && (in_wr_addr == {m_hi, m_lo});
        clr = 32'h0;
        if (reg_wr) begin
            if (reg_addr == 3'd0) m_lo = reg_wdata;
            if (reg_addr == 3'd1) m_hi = reg_wdata;
            if (reg_addr == 3'd2) clr = reg_wdata;
            if (reg_addr == 3'd3) m_mask = reg_wdata;
        end
        m_stat = m_stat & ~clr;
        if (cap) begin
            m_stat = m_stat | (32'h1 << in_wr_data_lo[4:0]);
            m_pay  = in_wr_data_lo;
        end
    endtask

    // one clock: update the model at the edge, compare at the falling edge
    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " pending"}, 32'(msi_pending), 32'((m_stat & ~m_mask) != 0));
        chk({tag, " rdata"}, reg_rdata, m_read(reg_addr));
    endtask

    task automatic idle();
        in_wr_valid = 1'b0;
        reg_wr      = 1'b0;
    endtask

    task automatic regw(input bit [2:0] idx, input bit [31:0] val, input string tag);
        reg_wr = 1'b1; reg_addr = idx; reg_wdata = val;
        cyc(tag);
        idle();
    endtask

    task automatic msiw(input bit [63:0] a, input bit [7:0] d, input string tag);
        in_wr_valid = 1'b1; in_wr_addr = a; in_wr_data_lo = d;
        cyc(tag);
        idle();
    endtask

    task automatic rd(input bit [2:0] idx, input bit [31:0] exp, input string tag);
        reg_addr = idx;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    localparam bit [63:0] TGT = 64'h0000_0001_FEE0_1000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_lo = 0; m_hi = 0; m_stat = 0; m_mask = 0; m_pay = 0;
        for (int i = 0; i < 8; i++) rd(3'(i), 32'h0, "R1 reset read");
        chk("R1 reset pending", 32'(msi_pending), 32'h0);

        regw(3'd0, TGT[31:0], "R9 write lo");
        regw(3'd1, TGT[63:32], "R9 write hi");
        rd(3'd0, 32'hFEE0_1000, "R9 lo readback");
        rd(3'd1, 32'h0000_0001, "R9 hi readback");

        msiw(TGT, 8'h03, "R3 disabled write");
        rd(3'd2, 32'h0, "R3 disabled no status");
        rd(3'd4, 32'h0, "R3 disabled no payload");

        msi_en = 1'b1;
        msiw(TGT, 8'h03, "R2 capture v3");
        rd(3'd2, 32'h0000_0008, "R2 status v3");
        rd(3'd4, 32'h0000_0003, "R4 payload v3");
        chk("R7 pending on", 32'(msi_pending), 32'h1);

        msiw(TGT, 8'hFF, "R2 capture v31");
        rd(3'd2, 32'h8000_0008, "R2 status v31");
        rd(3'd4, 32'h0000_00FF, "R4 payload upper zero");

        msiw({32'h0, TGT[31:0]}, 8'h01, "R9 high half mismatch");
        msiw({TGT[63:32], 32'hFEE0_1004}, 8'h02, "R3 low half mismatch");
        rd(3'd2, 32'h8000_0008, "R3 status unchanged");
        rd(3'd4, 32'h0000_00FF, "R3 payload unchanged");

        regw(3'd3, 32'h0000_0008, "R7 mask v3");
        chk("R7 pending with v31", 32'(msi_pending), 32'h1);
        regw(3'd3, 32'hFFFF_FFFF, "R7 mask all");
        chk("R7 pending all masked", 32'(msi_pending), 32'h0);
        msiw(TGT, 8'h25, "R8 capture masked v5");
        rd(3'd2, 32'h8000_0028, "R8 masked bit set");
        chk("R8 pending stays low", 32'(msi_pending), 32'h0);

        regw(3'd3, 32'h0, "R7 unmask");
        regw(3'd2, 32'h0000_0008, "R5 clear v3");
        rd(3'd2, 32'h8000_0020, "R5 only v3 cleared");
        regw(3'd2, 32'h0, "R5 write zero");
        rd(3'd2, 32'h8000_0020, "R5 zero keeps bits");

        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h0000_00A0;
        in_wr_valid = 1'b1; in_wr_addr = TGT; in_wr_data_lo = 8'h07;
        cyc("R6 set and clear");
        idle();
        rd(3'd2, 32'h8000_0080, "R6 set wins");
        rd(3'd4, 32'h0000_0007, "R4 payload v7");

        regw(3'd4, 32'h0000_0055, "R10 payload write");
        rd(3'd4, 32'h0000_0007, "R10 payload unchanged");
        regw(3'd6, 32'hFFFF_FFFF, "R10 unmapped write");
        rd(3'd6, 32'h0, "R10 unmapped read");
        rd(3'd5, 32'h0, "R10 index5 read");
        rd(3'd3, 32'h0, "R10 mask unchanged");

        regw(3'd2, 32'hFFFF_FFFF, "R5 clear all");
        rd(3'd2, 32'h0, "R5 all cleared");
        chk("R7 pending off", 32'(msi_pending), 32'h0);

        msi_en = 1'b0;
        for (int k = 0; k < 4; k++) msiw(TGT, 8'(k), "R3 disabled burst");
        rd(3'd2, 32'h0, "R3 burst ignored");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule